// File: doc/BRIEF.md
# Sample-and-Hold Refresh Sequencer

This controller lets a converter output stay valid while the converter itself is powered for only part of the time. Once the mode is enabled, it runs a fixed cycle of phases. First the converter is powered with the output switch closed, so that it charges a hold capacitor. The switch then opens while the converter stays powered for one more tick. After that the converter is switched off and the capacitor alone keeps the voltage. At the end of a programmed hold time the converter is powered again and the switch closes to top up the charge. The hold and refresh steps then repeat without further software involvement. The duty cycle is set by three tick counts: sample length, hold length and refresh length.

The phase timers advance on a low-speed tick enable. The block itself runs on the fast clock. Data values written while the sequence runs are stored in a pending register. They reach the converter only at the start of a charging phase, so the converter code never changes while the capacitor is floating. With the mode disabled, the block sits in idle with the converter powered and the switch closed, and writes pass through after one clock.

States and transitions (phase code in brackets): IDLE [0] goes to SAMPLE [1] on the first clock with the mode enabled. SAMPLE goes to ISOLATE [2] on its last tick. ISOLATE goes to HOLD [3] after one tick. HOLD goes to REFRESH [4] on its last tick. REFRESH goes to ISOLATE on its last tick. From any state, the block goes to IDLE on the first clock with the mode disabled.

Top module: `sh_refresh_seq`

## Requirements
- R1: After reset the phase is IDLE (code 0), `conv_en` is 1, `sw_close` is 1 and `conv_data` is 0.
- R2: With `mode_en` high in IDLE, the phase becomes SAMPLE (code 1) at the next clock edge, whether or not `tick` is high.
- R3: SAMPLE, HOLD and REFRESH last exactly `sample_len`, `hold_len` and `refresh_len` ticks. A length of 0 acts as 1. A phase changes only on a clock where `tick` is high, except for entry from IDLE and return to IDLE.
- R4: Every SAMPLE and every REFRESH is followed by exactly one tick of ISOLATE (code 2). In ISOLATE the converter is on and the switch is open, so the switch always opens one tick before the converter turns off.
- R5: ISOLATE is always followed by HOLD (code 3). HOLD is always followed by REFRESH (code 4). Once started, the sequence never returns to SAMPLE unless it passes through IDLE.
- R6: `sw_close` is 1 exactly in IDLE, SAMPLE and REFRESH. `conv_en` is 0 exactly in HOLD.
- R7: With `mode_en` low at a clock edge, the block is in IDLE after that edge, from any phase.
- R8: A value written with `wr_valid` is held as pending. `conv_data` takes the pending value on every clock in IDLE, and on the edge that enters SAMPLE or REFRESH. It stays unchanged at all other times, in particular during HOLD.
- R9: `phase` reports the state with the codes IDLE=0, SAMPLE=1, ISOLATE=2, HOLD=3, REFRESH=4.
- R10: Each phase length is sampled on the edge that enters the phase. A change to a length register while the phase runs takes effect at the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Sample-and-hold mode enable |
| tick | input | 1 | Low-speed tick enable for the phase timers |
| sample_len | input | CW | Sample phase length in ticks |
| hold_len | input | CW | Hold phase length in ticks |
| refresh_len | input | CW | Refresh phase length in ticks |
| wr_valid | input | 1 | Data write strobe |
| wr_data | input | DW | Data value to write |
| conv_en | output | 1 | Converter power enable |
| sw_close | output | 1 | Output switch closed |
| phase | output | 3 | Current phase code |
| conv_data | output | DW | Code applied to the converter |

## Verification
The bench builds the block with CW=3 and DW=8. Every length from 0 to the all-ones value of 7 is therefore hit many times during random runs with sparse ticks. An 8-bit data path is enough to tell apart writes that land in different phases. Directed segments cover the cases that random stimulus reaches only by chance:
- entry with no tick,
- all-zero lengths,
- a length change in mid-phase,
- a write during HOLD,
- a mode drop during HOLD.

// File: rtl/sh_seq_pkg.sv
package sh_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SAMPLE  = 3'd1,
        PH_ISOLATE = 3'd2,
        PH_HOLD    = 3'd3,
        PH_REFRESH = 3'd4
    } sh_phase_e;
endpackage

// File: rtl/sh_tick_counter.sv
// Down counter for phase timing; zero or one loaded means a single tick.
module sh_tick_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt > ONE)) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = (cnt <= ONE);
endmodule

// File: rtl/sh_phase_fsm.sv
module sh_phase_fsm
    import sh_seq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_en,
    input  logic          tick,
    input  logic          last,
    input  logic [CW-1:0] sample_len,
    input  logic [CW-1:0] hold_len,
    input  logic [CW-1:0] refresh_len,
    output sh_phase_e     state,
    output logic          cnt_load,
    output logic [CW-1:0] cnt_val,
    output logic          charge_start,
    output logic          conv_en,
    output logic          sw_close
);
    sh_phase_e nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= nxt;
    end

    // next state and counter load
    always_comb begin
        nxt          = state;
        cnt_load     = 1'b0;
        cnt_val      = '0;
        charge_start = 1'b0;
        if (!mode_en) begin
            nxt = PH_IDLE;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    nxt          = PH_SAMPLE;
                    cnt_load     = 1'b1;
                    cnt_val      = sample_len;
                    charge_start = 1'b1;
                end
                PH_SAMPLE, PH_REFRESH: begin
                    if (tick && last) nxt = PH_ISOLATE;
                end
                PH_ISOLATE: begin
                    if (tick) begin
                        nxt      = PH_HOLD;
                        cnt_load = 1'b1;
                        cnt_val  = hold_len;
                    end
                end
                PH_HOLD: begin
                    if (tick && last) begin
                        nxt          = PH_REFRESH;
                        cnt_load     = 1'b1;
                        cnt_val      = refresh_len;
                        charge_start = 1'b1;
                    end
                end
                default: nxt = PH_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        unique case (state)
            PH_IDLE, PH_SAMPLE, PH_REFRESH: begin
                conv_en  = 1'b1;
                sw_close = 1'b1;
            end
            PH_ISOLATE: begin
                conv_en  = 1'b1;
                sw_close = 1'b0;
            end
            PH_HOLD: begin
                conv_en  = 1'b0;
                sw_close = 1'b0;
            end
            default: begin
                conv_en  = 1'b1;
                sw_close = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sh_data_latch.sv
// Pending write register plus the code presented to the converter.
module sh_data_latch #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          capture,
    output logic [DW-1:0] conv_data
);
    logic [DW-1:0] pending;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= '0;
            conv_data <= '0;
        end else begin
            if (wr_valid) pending   <= wr_data;
            if (capture)  conv_data <= pending;
        end
    end
endmodule

// File: rtl/sh_refresh_seq.sv
module sh_refresh_seq
    import sh_seq_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_en,
    input  logic          tick,
    input  logic [CW-1:0] sample_len,
    input  logic [CW-1:0] hold_len,
    input  logic [CW-1:0] refresh_len,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    output logic          conv_en,
    output logic          sw_close,
    output logic [2:0]    phase,
    output logic [DW-1:0] conv_data
);
    sh_phase_e     state;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          last;
    logic          charge_start;
    logic          capture;

    sh_phase_fsm #(.CW(CW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_en      (mode_en),
        .tick         (tick),
        .last         (last),
        .sample_len   (sample_len),
        .hold_len     (hold_len),
        .refresh_len  (refresh_len),
        .state        (state),
        .cnt_load     (cnt_load),
        .cnt_val      (cnt_val),
        .charge_start (charge_start),
        .conv_en      (conv_en),
        .sw_close     (sw_close)
    );

    sh_tick_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (tick),
        .last     (last)
    );

    assign capture = (state == PH_IDLE) || charge_start;

    sh_data_latch #(.DW(DW)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .capture   (capture),
        .conv_data (conv_data)
    );

    assign phase = state;
endmodule

// File: rtl/sh_refresh_seq_chk.sv
module sh_refresh_seq_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_en,
    input logic          tick,
    input logic          conv_en,
    input logic          sw_close,
    input logic [2:0]    phase,
    input logic [DW-1:0] conv_data
);
    p_idle_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (phase == 3'd0 && conv_en && sw_close));

    p_open_before_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_en) |-> $past(!sw_close));

    p_sample_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd1 && phase != 3'd1) |-> (phase == 3'd2 || phase == 3'd0));

    p_hold_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd3 && phase != 3'd3) |-> (phase == 3'd4 || phase == 3'd0));

    p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3) |-> $stable(conv_data));

    p_ticked_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase) && $past(phase) != 3'd0 && phase != 3'd0) |-> $past(tick));

    p_off_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd3) |-> (!conv_en && !sw_close));
endmodule

bind sh_refresh_seq sh_refresh_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_en   (mode_en),
    .tick      (tick),
    .conv_en   (conv_en),
    .sw_close  (sw_close),
    .phase     (phase),
    .conv_data (conv_data)
);

// File: tb/sim_sh_refresh_seq.sv
module sim_sh_refresh_seq;
    localparam int CW = 3;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_en = 1'b0;
    logic          tick = 1'b0;
    logic [CW-1:0] sample_len = '0;
    logic [CW-1:0] hold_len = '0;
    logic [CW-1:0] refresh_len = '0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          conv_en;
    logic          sw_close;
    logic [2:0]    phase;
    logic [DW-1:0] conv_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string seg = "R1";

    // reference model state
    int            m_ph = 0;
    int            m_left = 0;
    logic [DW-1:0] m_pend = '0;
    logic [DW-1:0] m_data = '0;

    always #4 clk = ~clk;

    sh_refresh_seq #(.CW(CW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .tick(tick),
        .sample_len(sample_len), .hold_len(hold_len), .refresh_len(refresh_len),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .conv_en(conv_en), .sw_close(sw_close), .phase(phase), .conv_data(conv_data)
    );

    function automatic int len1(input logic [CW-1:0] v);
        return (v == '0) ? 1 : int'(v);
    endfunction

    function automatic logic exp_conv(input int p);
        return p != 3;
    endfunction

    function automatic logic exp_sw(input int p);
        return (p == 0) || (p == 1) || (p == 4);
    endfunction

    // model from the requirements: phase codes R9, lengths R3/R10, data R8
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_pend = '0; m_data = '0;
        end else begin
            int  nph;
            logic cap;
            nph = m_ph;
            cap = (m_ph == 0);
            if (!mode_en) begin
                nph = 0;
            end else begin
                case (m_ph)
                    0: begin nph = 1; m_left = len1(sample_len); end
                    1, 4: if (tick) begin
                        m_left--;
                        if (m_left == 0) nph = 2;
                    end
                    2: if (tick) begin nph = 3; m_left = len1(hold_len); end
                    3: if (tick) begin
                        m_left--;
                        if (m_left == 0) begin
                            nph = 4; m_left = len1(refresh_len); cap = 1'b1;
                        end
                    end
                    default: nph = 0;
                endcase
            end
            if (cap) m_data = m_pend;
            if (wr_valid) m_pend = wr_data;
            m_ph = nph;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s (segment %s) act=%0d exp=%0d at cycle %0d", req, seg, act, exp, cycles);
        end
    endtask

    task automatic compare();
        chk("R9 phase", int'(phase), m_ph);
        chk("R6 conv_en", int'(conv_en), int'(exp_conv(m_ph)));
        chk("R6 sw_close", int'(sw_close), int'(exp_sw(m_ph)));
        chk("R8 conv_data", int'(conv_data), int'(m_data));
    endtask

    // one clock per iteration: check, then drive the next inputs
    task automatic run(input int n, input int tick_pct, input int wr_pct, input int drop_pm);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            tick     = ($urandom % 100) < tick_pct;
            wr_valid = ($urandom % 100) < wr_pct;
            wr_data  = DW'($urandom);
            if (drop_pm > 0) mode_en = !(($urandom % 1000) < drop_pm);
        end
    endtask

    task automatic wait_phase(input int p);
        for (int g = 0; g < 200 && m_ph != p; g++) run(1, 100, 0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        seg = "R1";
        chk("R1 phase", int'(phase), 0);
        chk("R1 conv_en", int'(conv_en), 1);
        chk("R1 sw_close", int'(sw_close), 1);
        chk("R1 conv_data", int'(conv_data), 0);

        // R2: entry without any tick
        seg = "R2";
        sample_len = 3'd2; hold_len = 3'd3; refresh_len = 3'd1;
        mode_en = 1'b1;
        run(4, 0, 0, 0);
        chk("R2 phase in SAMPLE without tick", int'(phase), 1);

        // R3, R4, R5: steady ticking through several cycles
        seg = "R4";
        run(25, 100, 0, 0);
        seg = "R3";
        run(60, 40, 0, 0);

        // R8: write during HOLD shows up at REFRESH
        seg = "R8";
        wait_phase(3);
        run(1, 0, 0, 0);
        wr_valid = 1'b1; wr_data = 8'hA5;
        run(1, 0, 0, 0);
        chk("R8 held during HOLD", int'(conv_data == 8'hA5), 0);
        wait_phase(4);
        run(1, 0, 0, 0);
        chk("R8 applied at REFRESH", int'(conv_data), 8'hA5);

        // R7: drop the mode in HOLD
        seg = "R7";
        wait_phase(3);
        run(1, 0, 0, 0);
        mode_en = 1'b0;
        run(1, 0, 0, 0);
        chk("R7 idle after drop", int'(phase), 0);
        run(3, 50, 50, 0);
        mode_en = 1'b1;

        // R3: zero lengths act as one tick
        seg = "R3";
        sample_len = '0; hold_len = '0; refresh_len = '0;
        run(20, 100, 0, 0);

        // R10: length change mid-phase
        seg = "R10";
        sample_len = 3'd5; hold_len = 3'd6; refresh_len = 3'd4;
        wait_phase(3);
        run(1, 100, 0, 0);
        hold_len = 3'd1; refresh_len = 3'd7;
        run(40, 100, 0, 0);

        // R5 and R6: long random run with occasional mode drops
        seg = "R5";
        for (int blk = 0; blk < 200; blk++) begin
            sample_len = CW'($urandom); hold_len = CW'($urandom); refresh_len = CW'($urandom);
            run(100, 30, 15, 4);
        end
        mode_en = 1'b1;
        run(20, 100, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule